// File: doc/BRIEF.md
# Programmable Product-Term Plane

This block is the AND plane of a small programmable logic device, with a fixed OR stage added after it. Sixteen logic signals come in. Each signal is split into a true copy and an inverted copy, which gives 32 array columns.

A stored connection map has 64 rows of 32 bits. It decides which columns take part in each row's product term. The 64 terms are grouped into eight blocks of eight, and each block is ORed into one sum output. Both the terms and the sums are combinational functions of the signals and the stored map.

The map is written one row at a time through either of two write ports:

- **Parallel port:** loads a whole row in a single clock cycle.
- **Serial port:** shifts a row in bit by bit. A small loader state machine controls it.

The loader state machine has three states:

- **LD_IDLE:** waits for a start request.
- **LD_SHIFT:** collects 32 bits.
- **LD_COMMIT:** writes the collected row into the map in a single cycle.

It has three transitions:

- **start** (LD_IDLE to LD_SHIFT): taken on `ser_begin`.
- **full** (LD_SHIFT to LD_COMMIT): taken when the 32nd valid bit arrives.
- **done** (LD_COMMIT to LD_IDLE): taken unconditionally.

Top module: `pterm_plane`

## Requirements
- R1: After reset the whole map is cleared. Every term output and every sum output reads 1, and `ser_busy` reads 0.
- R2: A row whose 32 map bits are all 0 (nothing connected) drives its term output to 1 for any input values.
- R3: A row that connects both column 2i and column 2i+1 for some signal i drives its term output to 0 for any input values.
- R4: Column 2i carries `sig_in[i]` and column 2i+1 carries its inverse. Map bit c of row r set to 1 means column c is connected. `term_out[r]` is the AND of the connected columns, and it follows `sig_in` in the same cycle with no clock in between.
- R5: `sum_out[g]` is the OR of `term_out[8g]` through `term_out[8g+7]`.
- R6: When `par_we` is 1 at a rising edge, `par_data` replaces row `par_row`, and the new row is visible right after that edge.
- R7: Serial loading works in four steps:
  - `ser_begin` in LD_IDLE latches `ser_row`, enters LD_SHIFT and raises `ser_busy` after that edge.
  - Each edge with `ser_valid` high takes one bit from `ser_bit`. The first bit taken lands in column 0 and the 32nd lands in column 31.
  - The edge that takes the 32nd bit moves the loader to LD_COMMIT.
  - The next edge writes the row and returns to LD_IDLE with `ser_busy` at 0.
- R8: `ser_begin` while `ser_busy` is 1 has no effect. Neither the target row of the load in progress nor the row named by the stray request is changed, beyond what the load itself writes.
- R9: If a parallel write and a serial commit land on the same edge:
  - When they address the same row, the parallel data is stored.
  - When they address different rows, both rows are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the map and the loader |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_in | input | 16 | Logic signals feeding the array |
| par_we | input | 1 | Parallel row write strobe |
| par_row | input | 6 | Row index for a parallel write |
| par_data | input | 32 | Row contents for a parallel write |
| ser_begin | input | 1 | Starts a serial row load |
| ser_row | input | 6 | Row index latched at serial start |
| ser_valid | input | 1 | Qualifies `ser_bit` during a serial load |
| ser_bit | input | 1 | Serial map bit, column 0 first |
| ser_busy | output | 1 | Serial loader is shifting or committing |
| term_out | output | 64 | Product-term values, one per row |
| sum_out | output | 8 | OR of each group of eight terms |

## Verification
The serial loader's commit cycle and a parallel row write can meet on the same clock edge. This is the one place where two functions of the block compete for the map. The bench provokes it by raising `par_we` exactly in the LD_COMMIT cycle, once aimed at the row being committed and once at a different row. It then reads both rows back through `term_out`, using input patterns chosen so that each candidate row value gives a distinct term result. The same-row case must show the parallel data, and the different-row case must show both writes.

// File: rtl/pterm_pkg.sv
package pterm_pkg;
    parameter int N_SIG    = 16;
    parameter int N_OUT    = 8;
    parameter int TERMS_PO = 8;

    localparam int N_COL  = 2 * N_SIG;
    localparam int N_ROW  = N_OUT * TERMS_PO;
    localparam int ROW_W  = $clog2(N_ROW);
    localparam int CNT_W  = $clog2(N_COL);

    typedef enum logic [1:0] {
        LD_IDLE   = 2'd0,
        LD_SHIFT  = 2'd1,
        LD_COMMIT = 2'd2
    } ld_state_t;
endpackage

// File: rtl/pterm_serial_loader.sv
module pterm_serial_loader
    import pterm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_begin,
    input  logic [ROW_W-1:0] ser_row,
    input  logic             ser_valid,
    input  logic             ser_bit,
    output logic             busy,
    output logic             wr_en,
    output logic [ROW_W-1:0] wr_row,
    output logic [N_COL-1:0] wr_data
);
    ld_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [ROW_W-1:0] row_q;
    logic [N_COL-1:0] shreg_q;
    logic             last_bit;

    assign last_bit = ser_valid && (cnt_q == CNT_W'(N_COL - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_IDLE:   if (ser_begin) state_d = LD_SHIFT;
            LD_SHIFT:  if (last_bit)  state_d = LD_COMMIT;
            LD_COMMIT: state_d = LD_IDLE;
            default:   state_d = LD_IDLE;
        endcase
    end

    // datapath: row latch, bit counter, shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            row_q   <= '0;
            shreg_q <= '0;
        end else begin
            if (state_q == LD_IDLE && ser_begin) begin
                row_q <= ser_row;
                cnt_q <= '0;
            end
            if (state_q == LD_SHIFT && ser_valid) begin
                shreg_q <= {ser_bit, shreg_q[N_COL-1:1]};
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy  = 1'b0;
        wr_en = 1'b0;
        unique case (state_q)
            LD_IDLE:   busy = 1'b0;
            LD_SHIFT:  busy = 1'b1;
            LD_COMMIT: begin
                busy  = 1'b1;
                wr_en = 1'b1;
            end
            default:   busy = 1'b0;
        endcase
    end

    assign wr_row  = row_q;
    assign wr_data = shreg_q;
endmodule

// File: rtl/pterm_fuse_store.sv
module pterm_fuse_store
    import pterm_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ser_we,
    input  logic [ROW_W-1:0]       ser_row,
    input  logic [N_COL-1:0]       ser_data,
    input  logic                   par_we,
    input  logic [ROW_W-1:0]       par_row,
    input  logic [N_COL-1:0]       par_data,
    output logic [N_ROW*N_COL-1:0] map_flat
);
    logic [N_COL-1:0] map_q [N_ROW];

    // parallel write is applied last so it wins on a shared row
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < N_ROW; r++) begin
                map_q[r] <= '0;
            end
        end else begin
            if (ser_we) map_q[ser_row] <= ser_data;
            if (par_we) map_q[par_row] <= par_data;
        end
    end

    for (genvar r = 0; r < N_ROW; r++) begin : g_flat
        assign map_flat[r*N_COL +: N_COL] = map_q[r];
    end
endmodule

// File: rtl/pterm_eval.sv
module pterm_eval
    import pterm_pkg::*;
(
    input  logic [N_SIG-1:0]       sig_in,
    input  logic [N_ROW*N_COL-1:0] map_flat,
    output logic [N_ROW-1:0]       term_out,
    output logic [N_OUT-1:0]       sum_out
);
    logic [N_COL-1:0] col;

    for (genvar i = 0; i < N_SIG; i++) begin : g_col
        assign col[2*i]   = sig_in[i];
        assign col[2*i+1] = ~sig_in[i];
    end

    // unconnected columns are forced high before the AND
    for (genvar r = 0; r < N_ROW; r++) begin : g_term
        assign term_out[r] = &(col | ~map_flat[r*N_COL +: N_COL]);
    end

    for (genvar g = 0; g < N_OUT; g++) begin : g_sum
        assign sum_out[g] = |term_out[g*TERMS_PO +: TERMS_PO];
    end
endmodule

// File: rtl/pterm_plane.sv
module pterm_plane
    import pterm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SIG-1:0] sig_in,
    input  logic             par_we,
    input  logic [ROW_W-1:0] par_row,
    input  logic [N_COL-1:0] par_data,
    input  logic             ser_begin,
    input  logic [ROW_W-1:0] ser_row,
    input  logic             ser_valid,
    input  logic             ser_bit,
    output logic             ser_busy,
    output logic [N_ROW-1:0] term_out,
    output logic [N_OUT-1:0] sum_out
);
    logic                   ld_we;
    logic [ROW_W-1:0]       ld_row;
    logic [N_COL-1:0]       ld_data;
    logic [N_ROW*N_COL-1:0] map_flat;

    pterm_serial_loader u_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_begin (ser_begin),
        .ser_row   (ser_row),
        .ser_valid (ser_valid),
        .ser_bit   (ser_bit),
        .busy      (ser_busy),
        .wr_en     (ld_we),
        .wr_row    (ld_row),
        .wr_data   (ld_data)
    );

    pterm_fuse_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_we   (ld_we),
        .ser_row  (ld_row),
        .ser_data (ld_data),
        .par_we   (par_we),
        .par_row  (par_row),
        .par_data (par_data),
        .map_flat (map_flat)
    );

    pterm_eval u_eval (
        .sig_in   (sig_in),
        .map_flat (map_flat),
        .term_out (term_out),
        .sum_out  (sum_out)
    );
endmodule

// File: rtl/pterm_plane_chk.sv
module pterm_plane_chk
    import pterm_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   par_we,
    input  logic [ROW_W-1:0]       par_row,
    input  logic [N_COL-1:0]       par_data,
    input  logic                   ser_begin,
    input  logic                   ser_busy,
    input  logic [N_ROW-1:0]       term_out,
    input  logic [N_ROW*N_COL-1:0] map_flat
);
    function automatic logic has_clash(input logic [N_COL-1:0] f);
        logic c;
        c = 1'b0;
        for (int i = 0; i < N_SIG; i++) begin
            c = c | (f[2*i] & f[2*i+1]);
        end
        return c;
    endfunction

    for (genvar r = 0; r < N_ROW; r++) begin : g_row
        // R2: empty row reads high
        a_r2_empty_high: assert property (@(posedge clk) disable iff (!rst_n)
            (map_flat[r*N_COL +: N_COL] == '0) |-> term_out[r]);
        // R3: true and complement of one signal reads low
        a_r3_clash_low: assert property (@(posedge clk) disable iff (!rst_n)
            has_clash(map_flat[r*N_COL +: N_COL]) |-> !term_out[r]);
    end

    // R6: parallel data appears in the addressed row after the edge
    a_r6_par_write: assert property (@(posedge clk) disable iff (!rst_n)
        par_we |=> (map_flat[$past(par_row)*N_COL +: N_COL] == $past(par_data)));

    // R7: a start request from idle makes the loader busy
    a_r7_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_busy && ser_begin) |=> ser_busy);
endmodule

bind pterm_plane pterm_plane_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .par_we    (par_we),
    .par_row   (par_row),
    .par_data  (par_data),
    .ser_begin (ser_begin),
    .ser_busy  (ser_busy),
    .term_out  (term_out),
    .map_flat  (map_flat)
);

// File: tb/pterm_plane_test.sv
`timescale 1ns/1ps
module pterm_plane_test;
    import pterm_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_SIG-1:0] sig_in = '0;
    logic             par_we = 1'b0;
    logic [ROW_W-1:0] par_row = '0;
    logic [N_COL-1:0] par_data = '0;
    logic             ser_begin = 1'b0;
    logic [ROW_W-1:0] ser_row = '0;
    logic             ser_valid = 1'b0;
    logic             ser_bit = 1'b0;
    logic             ser_busy;
    logic [N_ROW-1:0] term_out;
    logic [N_OUT-1:0] sum_out;

    always #2 clk = ~clk;

    pterm_plane uut (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in),
        .par_we(par_we), .par_row(par_row), .par_data(par_data),
        .ser_begin(ser_begin), .ser_row(ser_row), .ser_valid(ser_valid),
        .ser_bit(ser_bit), .ser_busy(ser_busy),
        .term_out(term_out), .sum_out(sum_out)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        string            tag;
        logic [N_ROW-1:0] t;
        logic [N_OUT-1:0] s;
    } exp_t;
    exp_t sb_q[$];

    logic [N_COL-1:0] mdl [N_ROW];

    function automatic logic [N_ROW-1:0] mdl_terms(input logic [N_SIG-1:0] s);
        logic [N_ROW-1:0] t;
        for (int r = 0; r < N_ROW; r++) begin
            t[r] = 1'b1;
            for (int c = 0; c < N_COL; c++) begin
                if (mdl[r][c]) begin
                    t[r] = t[r] & ((c % 2 == 0) ? s[c/2] : !s[c/2]);
                end
            end
        end
        return t;
    endfunction

    function automatic logic [N_OUT-1:0] mdl_sums(input logic [N_ROW-1:0] t);
        logic [N_OUT-1:0] o;
        for (int g = 0; g < N_OUT; g++) begin
            o[g] = 1'b0;
            for (int k = 0; k < TERMS_PO; k++) o[g] = o[g] | t[g*TERMS_PO + k];
        end
        return o;
    endfunction

    // driver side: push expected outputs for the current inputs
    task automatic expect_now(input string tag);
        exp_t e;
        e.tag = tag;
        e.t = mdl_terms(sig_in);
        e.s = mdl_sums(e.t);
        sb_q.push_back(e);
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    // monitor: compare queued expectations away from the rising edge
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                total++;
                if (term_out !== e.t) begin
                    bad++;
                    $display("FAIL %s terms: got %h expected %h", e.tag, term_out, e.t);
                end
                total++;
                if (sum_out !== e.s) begin
                    bad++;
                    $display("FAIL %s sums (R5): got %b expected %b", e.tag, sum_out, e.s);
                end
            end
        end
    end

    task automatic settle();
        @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic par_write(input int row, input logic [N_COL-1:0] d);
        @(posedge clk); #1;
        par_we = 1'b1; par_row = ROW_W'(row); par_data = d;
        @(posedge clk); #1;
        par_we = 1'b0;
        mdl[row] = d;
    endtask

    // serial load; optional stray start and parallel write in the commit cycle
    task automatic ser_load(input int row, input logic [N_COL-1:0] d,
                            input int stray_row, input int pw_row,
                            input logic [N_COL-1:0] pw_data);
        @(posedge clk); #1;
        ser_begin = 1'b1; ser_row = ROW_W'(row);
        @(posedge clk); #1;
        ser_begin = 1'b0;
        check_bit("R7 busy after start", ser_busy, 1'b1);
        for (int i = 0; i < N_COL; i++) begin
            ser_valid = 1'b1; ser_bit = d[i];
            if (stray_row >= 0 && i == 5) begin
                ser_begin = 1'b1; ser_row = ROW_W'(stray_row);
            end else begin
                ser_begin = 1'b0;
            end
            @(posedge clk); #1;
        end
        ser_valid = 1'b0; ser_begin = 1'b0;
        check_bit("R7 busy in commit", ser_busy, 1'b1);
        if (pw_row >= 0) begin
            par_we = 1'b1; par_row = ROW_W'(pw_row); par_data = pw_data;
        end
        @(posedge clk); #1;
        par_we = 1'b0;
        check_bit("R7 idle after commit", ser_busy, 1'b0);
        mdl[row] = d;
        if (pw_row >= 0) mdl[pw_row] = pw_data;
    endtask

    function automatic logic [N_COL-1:0] sparse_row();
        logic [N_COL-1:0] f;
        for (int c = 0; c < N_COL; c++) f[c] = ($urandom % 16) == 0;
        return f;
    endfunction

    initial begin
        #300000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < N_ROW; r++) mdl[r] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        check_bit("R1 busy after reset", ser_busy, 1'b0);
        sig_in = 16'hA5C3; expect_now("R1 reset map");
        settle();

        // R2 / R4: empty row high under several patterns
        for (int k = 0; k < 4; k++) begin
            sig_in = N_SIG'($urandom); expect_now("R2 empty rows");
            settle();
        end

        // R3: contradictory rows
        par_write(3, 32'h0000_0003);        // signal 0 both forms
        par_write(40, 32'h0C00_0010);       // signal 13 both forms plus one more
        sig_in = 16'h0000; expect_now("R3 clash sig low"); settle();
        sig_in = 16'hFFFF; expect_now("R3 clash sig high"); settle();

        // R4: single-column rows follow inputs in the same cycle
        par_write(9, 32'h0000_0001 << 14);  // true of signal 7
        par_write(10, 32'h0000_0001 << 15); // complement of signal 7
        sig_in = 16'h0080; expect_now("R4 bit7 set"); settle();
        sig_in = 16'h0000; expect_now("R4 bit7 clear"); settle();

        // R4 / R5 / R6: random sparse maps via parallel port
        for (int m = 0; m < 3; m++) begin
            for (int r = 0; r < N_ROW; r++) par_write(r, sparse_row());
            for (int p = 0; p < 12; p++) begin
                sig_in = N_SIG'($urandom); expect_now("R6 random map");
                settle();
            end
        end

        // R7: serial load into a row, column 0 first
        ser_load(20, 32'h0000_0002 | (32'h1 << 31), -1, -1, '0);
        sig_in = 16'h0000; expect_now("R7 serial row a"); settle();
        sig_in = 16'h8000; expect_now("R7 serial row b"); settle();
        ser_load(21, 32'h0000_0001, -1, -1, '0);
        sig_in = 16'h0001; expect_now("R7 serial col0"); settle();
        sig_in = 16'h0000; expect_now("R7 serial col0 low"); settle();

        // R8: stray start while busy must not redirect or touch row 30
        par_write(30, 32'h0000_0004);
        ser_load(31, 32'h0000_0008, 30, -1, '0);
        sig_in = 16'h0002; expect_now("R8 stray start a"); settle();
        sig_in = 16'h0000; expect_now("R8 stray start b"); settle();

        // R9: parallel write in the commit cycle, same row then other row
        ser_load(50, 32'h0000_0010, -1, 50, 32'h0000_0020);
        sig_in = 16'h0004; expect_now("R9 same row a"); settle();
        sig_in = 16'h0000; expect_now("R9 same row b"); settle();
        ser_load(51, 32'h0000_0040, -1, 52, 32'h0000_0080);
        sig_in = 16'h0008; expect_now("R9 both rows a"); settle();
        sig_in = 16'h0000; expect_now("R9 both rows b"); settle();

        // R1: reset again clears everything
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        for (int r = 0; r < N_ROW; r++) mdl[r] = '0;
        sig_in = 16'h1234; expect_now("R1 second reset"); settle();

        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule